// File: doc/BRIEF.md
# Key Event Queue with Encoded Read Byte

This block buffers debounced events from a 64-key matrix scanner until the host reads them. A scanner pushes one entry per key press or release, and the autorepeat logic pushes a repeat marker. Each entry is held in a 16-deep first-in first-out store. The contents are not touched by anything except pushes, pops and reset, so the queue keeps its data while the rest of the device sleeps.

The host reads the head of the queue as one byte and pops it with a one-cycle strobe. The byte holds the key number, a release flag and a flag that tells whether more data follows. Codes 0x3E and 0x3F, which would otherwise belong to keys 62 and 63, are reserved for the repeat marker, the empty reply and the overflow report. For that reason the two top keys always read with bit 7 set, and the host must read once more to learn whether anything remains. When a push arrives while the queue is full, the event is dropped and an overflow report is placed behind the entries already stored.

Top module: `keyq_top`

## Requirements
- R1: After a synchronous active-low reset, count is 0, empty is 1, full is 0 and the read byte is 0x3F.
- R2: Entries leave in the order they were pushed. The queue holds up to 16 entries. count gives the number of stored entries, empty is high at 0 entries and full is high at 16.
- R3: For a key entry with key number 0 to 61, the read byte is {more, release, key[5:0]}. Bit 7 (more) is 1 when at least one further entry or a pending overflow report follows this entry. Bit 6 is 1 for a release and 0 for a press. The key number is column*8 + row, supplied by the scanner.
- R4: For key 62 the read byte is 0xBE on a press and 0xFE on a release. For key 63 it is 0xBF on a press and 0xFF on a release. Bit 7 is 1 for these keys whatever follows.
- R5: A repeat-marker entry reads as 0x3E when it is the last data and as 0x7E when more data follows.
- R6: With no entries and no pending overflow report, the read byte is 0x3F. A pop in that state changes nothing.
- R7: A push while full is dropped. The count stays at 16 and the stored entries are unchanged.
- R8: After a dropped push, the read byte is 0x7F once every entry stored before the drop has been popped. Popping 0x7F removes only that report. Entries pushed afterwards then follow in order.
- R9: A push and an entry pop in the same cycle on a queue that is not full leave count unchanged.
- R10: When the key push and the repeat push are strobed in the same cycle, only the key event is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_push | input | 1 | Push one key event |
| evt_key | input | 6 | Key number of the event |
| evt_rel | input | 1 | 1 for a release, 0 for a press |
| rpt_push | input | 1 | Push one repeat marker |
| pop | input | 1 | Host has consumed the current read byte |
| rd_byte | output | 8 | Encoded head of the queue |
| count | output | 5 | Number of stored entries |
| empty | output | 1 | No entries stored |
| full | output | 1 | 16 entries stored |

## Verification
Pushes and pops are captured at one rising edge. count, empty, full and rd_byte are decoded without further registers from the state written at that edge, so every result is due at the edge that takes the strobe. The bench changes its inputs on the falling edge, lets exactly one rising edge pass, and samples on the next falling edge. Each strobe is therefore checked against the state it created, and no check can see a half-updated cycle. The overflow sequence is checked byte by byte over all sixteen pops, so the more-data bit of the last entry stored before the drop is checked as well.

// File: rtl/keyq_pkg.sv
// Shared types for the key event queue.
// Assumes six-bit key numbers (64-key matrix).
package keyq_pkg;
    localparam int KEY_W = 6;

    typedef enum logic [1:0] {
        ENT_KEY = 2'd0,
        ENT_RPT = 2'd1
    } ent_kind_t;

    typedef struct packed {
        ent_kind_t        kind;
        logic             rel;
        logic [KEY_W-1:0] key;
    } ent_t;
endpackage

// File: rtl/keyq_store.sv
// Circular storage of DEPTH entries with an occupancy count.
// Assumes the caller never writes when full and never reads when empty.
module keyq_store
    import keyq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  ent_t             wr_data,
    input  logic             rd_en,
    output ent_t             head,
    output logic [CNT_W-1:0] count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    ent_t             mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Write the incoming entry into the slot at the write pointer.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= wr_data;
    end

    // Advance the pointers and track the occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_en) wr_ptr <= bump(wr_ptr);
            if (rd_en) rd_ptr <= bump(rd_ptr);
            case ({wr_en, rd_en})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Present the oldest entry.
    assign head = mem[rd_ptr];
endmodule

// File: rtl/keyq_ovf.sv
// Overflow tracker. It holds a sticky flag and the number of entries still
// queued ahead of the overflow report.
// Assumes ent_pop and mark_pop are never high together.
module keyq_ovf #(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             drop,
    input  logic             ent_pop,
    input  logic             mark_pop,
    output logic             flag,
    output logic [CNT_W-1:0] ahead
);
    // Set on a drop, count entries down to the report, clear when it is read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag  <= 1'b0;
            ahead <= '0;
        end else if (drop) begin
            flag <= 1'b1;
            if (!flag || mark_pop)
                ahead <= ent_pop ? CNT_W'(DEPTH - 1) : CNT_W'(DEPTH);
            else if (ent_pop)
                ahead <= ahead - 1'b1;
        end else if (mark_pop) begin
            flag <= 1'b0;
        end else if (flag && ent_pop) begin
            ahead <= ahead - 1'b1;
        end
    end
endmodule

// File: rtl/keyq_enc.sv
// Builds the host read byte from the head entry, the count and the overflow state.
// Purely combinational.
module keyq_enc
    import keyq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  ent_t             head,
    input  logic [CNT_W-1:0] count,
    input  logic             ovf_flag,
    input  logic [CNT_W-1:0] ovf_ahead,
    output logic             mark_vis,
    output logic [7:0]       rd_byte
);
    logic more;

    // A further entry, or the overflow report right behind this one, follows.
    assign more     = (count > CNT_W'(1)) || (ovf_flag && ovf_ahead == CNT_W'(1));
    assign mark_vis = ovf_flag && (ovf_ahead == '0);

    // Choose between the reserved codes and the plain key encoding.
    always_comb begin
        if (mark_vis)
            rd_byte = 8'h7F;
        else if (count == '0)
            rd_byte = 8'h3F;
        else if (head.kind == ENT_RPT)
            rd_byte = {1'b0, more, 6'h3E};
        else if (head.key >= 6'd62)
            rd_byte = {1'b1, head.rel, head.key};
        else
            rd_byte = {more, head.rel, head.key};
    end
endmodule

// File: rtl/keyq_top.sv
// Key event queue top. It merges the two push sources, guards the queue
// against overflow and underflow, and presents the encoded head byte.
// Assumes one-cycle strobes, with the same clock as the scanner and the host.
module keyq_top
    import keyq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       evt_push,
    input  logic [5:0] evt_key,
    input  logic       evt_rel,
    input  logic       rpt_push,
    input  logic       pop,
    output logic [7:0] rd_byte,
    output logic [4:0] count,
    output logic       empty,
    output logic       full
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    ent_t             wr_data;
    ent_t             head;
    logic [CNT_W-1:0] cnt;
    logic             push_req, push_ok, drop;
    logic             ent_pop, mark_pop, mark_vis;
    logic             ovf_flag;
    logic [CNT_W-1:0] ovf_ahead;

    // A key event takes precedence over a repeat marker in the same cycle.
    always_comb begin
        wr_data.kind = evt_push ? ENT_KEY : ENT_RPT;
        wr_data.rel  = evt_push & evt_rel;
        wr_data.key  = evt_push ? evt_key : 6'h3E;
    end

    assign push_req = evt_push | rpt_push;
    assign full     = (cnt == CNT_W'(DEPTH));
    assign empty    = (cnt == '0);
    assign push_ok  = push_req & ~full;
    assign drop     = push_req & full;
    assign ent_pop  = pop & ~mark_vis & ~empty;
    assign mark_pop = pop & mark_vis;
    assign count    = 5'(cnt);

    keyq_store #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (push_ok),
        .wr_data (wr_data),
        .rd_en   (ent_pop),
        .head    (head),
        .count   (cnt)
    );

    keyq_ovf #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ovf (
        .clk      (clk),
        .rst_n    (rst_n),
        .drop     (drop),
        .ent_pop  (ent_pop),
        .mark_pop (mark_pop),
        .flag     (ovf_flag),
        .ahead    (ovf_ahead)
    );

    keyq_enc #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_enc (
        .head      (head),
        .count     (cnt),
        .ovf_flag  (ovf_flag),
        .ovf_ahead (ovf_ahead),
        .mark_vis  (mark_vis),
        .rd_byte   (rd_byte)
    );
endmodule

// File: rtl/keyq_chk.sv
// Port-level properties of the key event queue, bound to every keyq_top.
module keyq_chk #(
    parameter int DEPTH = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       evt_push,
    input logic [5:0] evt_key,
    input logic       rpt_push,
    input logic       pop,
    input logic [7:0] rd_byte,
    input logic [4:0] count,
    input logic       empty,
    input logic       full
);
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (count == 5'd0 && empty && !full));

    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= 5'(DEPTH));

    assert_full_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (full && (evt_push || rpt_push) && !pop) |=> (count == 5'(DEPTH)));

    assert_empty_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_byte == 8'h3F && pop && !evt_push && !rpt_push)
        |=> (empty && rd_byte == 8'h3F));

    assert_push_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!full && !empty && rd_byte != 8'h7F && pop && (evt_push || rpt_push))
        |=> $stable(count));

    assert_key_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_push && rpt_push && rd_byte == 8'h3F && !pop)
        |=> (count == 5'd1 && rd_byte[5:0] == $past(evt_key)));
endmodule

bind keyq_top keyq_chk #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_push (evt_push),
    .evt_key  (evt_key),
    .rpt_push (rpt_push),
    .pop      (pop),
    .rd_byte  (rd_byte),
    .count    (count),
    .empty    (empty),
    .full     (full)
);

// File: tb/sim_keyq_top.sv
module sim_keyq_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       evt_push, evt_rel, rpt_push, pop;
    logic [5:0] evt_key;
    logic [7:0] rd_byte;
    logic [4:0] count;
    logic       empty, full;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done  = 1'b0;

    always #5 clk = ~clk;

    keyq_top u0 (
        .clk(clk), .rst_n(rst_n), .evt_push(evt_push), .evt_key(evt_key),
        .evt_rel(evt_rel), .rpt_push(rpt_push), .pop(pop),
        .rd_byte(rd_byte), .count(count), .empty(empty), .full(full)
    );

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One cycle of stimulus, applied at a falling edge; the result is sampled
    // at the next falling edge, after the single rising edge in between.
    task automatic step(input logic ep, input logic [5:0] k, input logic r,
                        input logic rp, input logic pp);
        evt_push = ep; evt_key = k; evt_rel = r; rpt_push = rp; pop = pp;
        @(negedge clk);
        evt_push = 0; evt_key = 0; evt_rel = 0; rpt_push = 0; pop = 0;
    endtask

    task automatic t_reset;
        chk("R1", "count", 8'(count), 8'd0);
        chk("R1", "empty", 8'(empty), 8'd1);
        chk("R1", "full", 8'(full), 8'd0);
        chk("R1", "byte", rd_byte, 8'h3F);
    endtask

    task automatic t_order;
        step(1, 6'd5, 0, 0, 0);
        step(1, 6'd12, 1, 0, 0);
        step(0, 0, 0, 1, 0);
        chk("R2", "count 3", 8'(count), 8'd3);
        chk("R3", "press 5 more", rd_byte, 8'h85);
        step(0, 0, 0, 0, 1);
        chk("R3", "release 12 more", rd_byte, 8'hCC);
        step(0, 0, 0, 0, 1);
        chk("R5", "repeat last", rd_byte, 8'h3E);
        chk("R2", "count 1", 8'(count), 8'd1);
        step(0, 0, 0, 0, 1);
        chk("R2", "empty after drain", 8'(empty), 8'd1);
        chk("R6", "empty byte", rd_byte, 8'h3F);
    endtask

    task automatic t_repeat_more;
        step(0, 0, 0, 1, 0);
        step(1, 6'd3, 0, 0, 0);
        chk("R5", "repeat more", rd_byte, 8'h7E);
        step(0, 0, 0, 0, 1);
        chk("R3", "press 3 last", rd_byte, 8'h03);
        step(0, 0, 0, 0, 1);
    endtask

    task automatic t_high_keys;
        step(1, 6'd62, 0, 0, 0);
        step(1, 6'd62, 1, 0, 0);
        step(1, 6'd63, 0, 0, 0);
        step(1, 6'd63, 1, 0, 0);
        chk("R4", "62 press", rd_byte, 8'hBE);
        step(0, 0, 0, 0, 1);
        chk("R4", "62 release", rd_byte, 8'hFE);
        step(0, 0, 0, 0, 1);
        chk("R4", "63 press", rd_byte, 8'hBF);
        step(0, 0, 0, 0, 1);
        chk("R4", "63 release last", rd_byte, 8'hFF);
        step(0, 0, 0, 0, 1);
        chk("R4", "then empty", rd_byte, 8'h3F);
    endtask

    task automatic t_empty_pop;
        step(0, 0, 0, 0, 1);
        chk("R6", "count after empty pop", 8'(count), 8'd0);
        chk("R6", "byte after empty pop", rd_byte, 8'h3F);
        step(1, 6'd1, 0, 0, 0);
        chk("R6", "push after empty pop", rd_byte, 8'h01);
        chk("R6", "count 1", 8'(count), 8'd1);
        step(0, 0, 0, 0, 1);
    endtask

    task automatic t_push_pop;
        step(1, 6'd20, 0, 0, 0);
        step(1, 6'd21, 0, 0, 0);
        step(1, 6'd9, 1, 0, 1);
        chk("R9", "count kept", 8'(count), 8'd2);
        chk("R9", "head moved", rd_byte, 8'h95);
        step(0, 0, 0, 0, 1);
        chk("R9", "pushed entry", rd_byte, 8'h49);
        step(0, 0, 0, 0, 1);
    endtask

    task automatic t_dual;
        step(1, 6'd7, 0, 1, 0);
        chk("R10", "one entry", 8'(count), 8'd1);
        chk("R10", "key kept", rd_byte, 8'h07);
        step(0, 0, 0, 0, 1);
        chk("R10", "nothing behind", rd_byte, 8'h3F);
    endtask

    task automatic t_overflow;
        for (int i = 0; i < 16; i++) step(1, 6'(i), 0, 0, 0);
        chk("R2", "full flag", 8'(full), 8'd1);
        step(1, 6'd20, 0, 0, 0);
        chk("R7", "count after drop", 8'(count), 8'd16);
        chk("R7", "head unchanged", rd_byte, 8'h80);
        for (int i = 0; i < 16; i++) begin
            chk("R8", $sformatf("entry %0d", i), rd_byte, 8'h80 | 8'(i));
            step(0, 0, 0, 0, 1);
        end
        chk("R8", "report", rd_byte, 8'h7F);
        chk("R8", "empty under report", 8'(empty), 8'd1);
        step(1, 6'd33, 0, 0, 0);
        chk("R8", "report before new", rd_byte, 8'h7F);
        step(0, 0, 0, 0, 1);
        chk("R8", "new after report", rd_byte, 8'h21);
        step(0, 0, 0, 0, 1);
        chk("R8", "drained", rd_byte, 8'h3F);
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        evt_push = 0; evt_key = 0; evt_rel = 0; rpt_push = 0; pop = 0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_order();
        t_repeat_more();
        t_high_keys();
        t_empty_pop();
        t_push_pop();
        t_dual();
        t_overflow();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end
endmodule